// File: doc/BRIEF.md
# Format Track Sequencer

This block runs the parameter and execution steps of a floppy format-track command inside a disk controller. The surrounding controller decodes the command byte and pulses `cmd_start`. The block then takes five parameter bytes from the host data path. During execution it takes a stream of four-byte sector ID groups. For every group it issues one whole-sector write request to a media port. The request carries a linear sector address and the filler byte, and the media port repeats the filler over `SECT_BYTES` (512) bytes.

The host paces itself on `rqm`. A host byte counts only in a cycle where `host_we` and `rqm` are both high. While a media write is still waiting for its acknowledge, `rqm` is held low, so no further host bytes are taken. A write refused by the media port raises the not-writable result flag (bit 1 of the second result status byte). When the last byte has been taken and the last write has been acknowledged, the block pulses `done` and raises `dio`, so the controller can move to its result phase.

Top module: `fmt_track_seq`

## Requirements
- R1: After reset, `rqm`, `dio`, `busy`, `mw_req`, `st1_nw` and `done` are all 0.
- R2: A `cmd_start` pulse while idle sets `busy` and `rqm`, clears `dio` and clears `st1_nw`. `dio` stays 0 while `busy` is high.
- R3: The five parameter bytes are taken in this order: byte 0 is the drive select (bits 1:0 appear on `mw_drive`), byte 1 is the size code (ignored), byte 2 is the sector count SC, byte 3 is the gap length (ignored), byte 4 is the filler. Taking byte 4 starts execution.
- R4: Execution byte index mod 4 picks the role of the byte. Index 0 is the cylinder, which loads the track register. Index 1 is the head, which issues a write. Index 2 is the sector number, which is latched. Index 3 is the size, which is ignored.
- R5: The write address is (S − 1) + `cfg_spt` × (T × `cfg_sides` + H), taken modulo 2^ADDR_W. S is the latched sector number, T is the track register and H is the head byte. The SC parameter also loads S, so the first write uses S = SC.
- R6: Every write request carries the filler byte on `mw_fill`, to be repeated over SECT_BYTES bytes.
- R7: While `mw_req` is high and not acknowledged, `mw_req`, `mw_addr` and `mw_fill` hold steady, `rqm` is 0, and host bytes are ignored.
- R8: An acknowledge with `mw_ok` = 0 sets `st1_nw`. The flag stays set until the next accepted `cmd_start`.
- R9: Execution ends after 4×SC−2 bytes have been taken and the final write has been acknowledged. `done` then pulses for exactly one cycle, `dio` becomes 1, and `busy` and `rqm` become 0.
- R10: SC = 0 ends the command on the filler byte with a `done` pulse and no write request.
- R11: Host writes while idle change nothing: `busy`, `rqm` and `mw_req` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Format command decoded; start the parameter step |
| host_we | input | 1 | Host writes a byte to the data register |
| host_data | input | 8 | Host byte |
| cfg_spt | input | 8 | Sectors per track of the medium |
| cfg_sides | input | 2 | Number of sides of the medium |
| mw_ack | input | 1 | Media port accepts the current write |
| mw_ok | input | 1 | Write outcome, valid with mw_ack |
| rqm | output | 1 | Block is ready for a host byte |
| dio | output | 1 | Direction flag: 1 once results are due |
| busy | output | 1 | Parameter or execution step in progress |
| mw_req | output | 1 | Sector write request |
| mw_drive | output | 2 | Drive selected by parameter byte 0 |
| mw_addr | output | 16 | Linear sector address |
| mw_fill | output | 8 | Filler byte to repeat over the sector |
| st1_nw | output | 1 | Not-writable result flag |
| done | output | 1 | One-cycle end-of-execution pulse |

## Verification
The bench targets four things. The first write must use SC as its sector number: a design that used the first ID group's sector byte would emit every address one sector off. A junk byte is offered while a write is unacknowledged: a design that accepted it would shift every later byte's role and corrupt the following addresses. The bench uses SC = 1 and SC = 0: an end count of 4×SC would hang waiting for bytes, and a design without the zero check would wrap its limit or issue a stray write. The not-writable flag is failed on one write and then checked to clear on the next command: a non-sticky flag would read 0 at done, and a flag without the clear would leak into the next result.

// File: rtl/fmt_track_pkg.sv
package fmt_track_pkg;
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_PARAM = 2'd1,
      PH_EXEC  = 2'd2
   } phase_t;

   typedef enum logic [1:0] {
      ROLE_CYL  = 2'd0,
      ROLE_HEAD = 2'd1,
      ROLE_SEC  = 2'd2,
      ROLE_SIZE = 2'd3
   } role_t;

   localparam int PARAM_BYTES = 5;
endpackage

// File: rtl/fmt_param_cap.sv
module fmt_param_cap #(
   parameter int SC_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic            take,
   input  logic [7:0]      data,
   output logic [1:0]      drive,
   output logic [SC_W-1:0] sc,
   output logic [7:0]      fill,
   output logic            sc_load,
   output logic            last
);
   import fmt_track_pkg::*;
   localparam int STEP_W = $clog2(PARAM_BYTES);

   logic [STEP_W-1:0] step;

   assign sc_load = take && (step == STEP_W'(2));
   assign last    = take && (step == STEP_W'(PARAM_BYTES - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         step  <= '0;
         drive <= '0;
         sc    <= '0;
         fill  <= '0;
      end else if (clr) begin
         step <= '0;
      end else if (take) begin
         step <= last ? '0 : step + STEP_W'(1);
         case (step)
            STEP_W'(0): drive <= data[1:0];
            STEP_W'(2): sc    <= SC_W'(data);
            STEP_W'(4): fill  <= data;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/fmt_addr_calc.sv
module fmt_addr_calc #(
   parameter int ADDR_W    = 16,
   parameter int SPT_W     = 8,
   parameter int SIDES_W   = 2,
   parameter bit HEAD_FULL = 1'b1
) (
   input  logic [7:0]         sec,
   input  logic [7:0]         trk,
   input  logic [7:0]         head,
   input  logic [SPT_W-1:0]   spt,
   input  logic [SIDES_W-1:0] sides,
   output logic [ADDR_W-1:0]  addr
);
   logic [ADDR_W-1:0] head_v;

   generate
      if (HEAD_FULL) begin : g_head_byte
         assign head_v = ADDR_W'(head);
      end else begin : g_head_bit
         logic unused_hi;
         assign unused_hi = ^head[7:1];
         assign head_v    = ADDR_W'(head[0]);
      end
   endgenerate

   assign addr = ADDR_W'(sec) - ADDR_W'(1)
               + ADDR_W'(spt) * (ADDR_W'(trk) * ADDR_W'(sides) + head_v);
endmodule

// File: rtl/fmt_wr_port.sv
module fmt_wr_port #(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [7:0]        fill_in,
   input  logic              ack,
   input  logic              ok,
   input  logic              clr_flag,
   output logic              req,
   output logic [ADDR_W-1:0] addr,
   output logic [7:0]        fill,
   output logic              nw
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req  <= 1'b0;
         addr <= '0;
         fill <= '0;
         nw   <= 1'b0;
      end else begin
         if (req && ack) begin
            req <= 1'b0;
            if (!ok) nw <= 1'b1;
         end else if (issue && !req) begin
            req  <= 1'b1;
            addr <= addr_in;
            fill <= fill_in;
         end
         if (clr_flag) nw <= 1'b0;
      end
   end

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      req && !ack |=> req && $stable(addr) && $stable(fill)); // R7
   AST_NW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      nw && !clr_flag |=> nw); // R8
   AST_NW_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nw) |-> $past(req && ack && !ok)); // R8
endmodule

// File: rtl/fmt_track_seq.sv
module fmt_track_seq #(
   parameter int ADDR_W     = 16,
   parameter int SC_W       = 8,
   parameter int SPT_W      = 8,
   parameter int SIDES_W    = 2,
   parameter int SECT_BYTES = 512,
   parameter bit HEAD_FULL  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_start,
   input  logic               host_we,
   input  logic [7:0]         host_data,
   input  logic [SPT_W-1:0]   cfg_spt,
   input  logic [SIDES_W-1:0] cfg_sides,
   input  logic               mw_ack,
   input  logic               mw_ok,
   output logic               rqm,
   output logic               dio,
   output logic               busy,
   output logic               mw_req,
   output logic [1:0]         mw_drive,
   output logic [ADDR_W-1:0]  mw_addr,
   output logic [7:0]         mw_fill,
   output logic               st1_nw,
   output logic               done
);
   import fmt_track_pkg::*;
   localparam int CNT_W = SC_W + 2;

   generate
      if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_addr
         $error("ADDR_W must lie in 8..32");
      end
      if (SC_W < 1 || SC_W > 8) begin : g_bad_sc
         $error("SC_W must lie in 1..8");
      end
      if (SECT_BYTES < 1) begin : g_bad_sect
         $error("SECT_BYTES must be positive");
      end
   endgenerate

   phase_t            phase;
   logic [CNT_W-1:0]  cnt;
   logic [CNT_W-1:0]  lim;
   logic              end_pend;
   logic [7:0]        trk;
   logic [7:0]        sec;
   logic              accept, cmd_go, p_take, p_last, p_scld, issue;
   logic [SC_W-1:0]   sc;
   logic [7:0]        fill;
   logic [ADDR_W-1:0] calc_addr;
   role_t             role;

   assign busy   = (phase != PH_IDLE);
   assign rqm    = (phase == PH_PARAM) || (phase == PH_EXEC && !mw_req && !end_pend);
   assign accept = host_we && rqm;
   assign cmd_go = cmd_start && (phase == PH_IDLE);
   assign p_take = accept && (phase == PH_PARAM);
   assign role   = role_t'(cnt[1:0]);
   assign issue  = accept && (phase == PH_EXEC) && (role == ROLE_HEAD);
   assign lim    = {sc, 2'b00} - CNT_W'(2);

   fmt_param_cap #(.SC_W(SC_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .clr(cmd_go), .take(p_take), .data(host_data),
      .drive(mw_drive), .sc(sc), .fill(fill), .sc_load(p_scld), .last(p_last)
   );

   fmt_addr_calc #(.ADDR_W(ADDR_W), .SPT_W(SPT_W), .SIDES_W(SIDES_W),
                   .HEAD_FULL(HEAD_FULL)) u_addr (
      .sec(sec), .trk(trk), .head(host_data), .spt(cfg_spt), .sides(cfg_sides),
      .addr(calc_addr)
   );

   fmt_wr_port #(.ADDR_W(ADDR_W)) u_wr (
      .clk(clk), .rst_n(rst_n), .issue(issue), .addr_in(calc_addr), .fill_in(fill),
      .ack(mw_ack), .ok(mw_ok), .clr_flag(cmd_go),
      .req(mw_req), .addr(mw_addr), .fill(mw_fill), .nw(st1_nw)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase    <= PH_IDLE;
         cnt      <= '0;
         end_pend <= 1'b0;
         trk      <= '0;
         sec      <= '0;
         dio      <= 1'b0;
         done     <= 1'b0;
      end else begin
         done <= 1'b0;
         case (phase)
            PH_IDLE: begin
               if (cmd_start) begin
                  phase <= PH_PARAM;
                  dio   <= 1'b0;
               end
            end
            PH_PARAM: begin
               if (p_scld) sec <= host_data;
               if (p_last) begin
                  cnt <= '0;
                  if (sc == '0) begin
                     phase <= PH_IDLE;
                     done  <= 1'b1;
                     dio   <= 1'b1;
                  end else begin
                     phase <= PH_EXEC;
                  end
               end
            end
            PH_EXEC: begin
               if (end_pend && !mw_req) begin
                  end_pend <= 1'b0;
                  phase    <= PH_IDLE;
                  done     <= 1'b1;
                  dio      <= 1'b1;
               end else if (accept) begin
                  case (role)
                     ROLE_CYL: trk <= host_data;
                     ROLE_SEC: sec <= host_data;
                     default: ;
                  endcase
                  cnt <= cnt + CNT_W'(1);
                  if (cnt + CNT_W'(1) == lim) end_pend <= 1'b1;
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   AST_BUSY_DIO: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !dio); // R2
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R9
   AST_DONE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> dio && !busy && !mw_req); // R9
   AST_REQ_NO_RQM: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mw_req) |-> !rqm && busy); // R7
endmodule

// File: tb/fmt_track_seq_test.sv
module fmt_track_seq_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_start = 1'b0, host_we = 1'b0, mw_ack = 1'b0, mw_ok = 1'b1;
   logic [7:0] host_data = '0, cfg_spt = '0;
   logic [1:0] cfg_sides = '0;
   logic       rqm, dio, busy, mw_req, st1_nw, done;
   logic [1:0] mw_drive;
   logic [15:0] mw_addr;
   logic [7:0] mw_fill;
   int checks = 0, fails = 0, cycles = 0;

   always #4 clk = ~clk;

   fmt_track_seq uut (
      .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .host_we(host_we),
      .host_data(host_data), .cfg_spt(cfg_spt), .cfg_sides(cfg_sides),
      .mw_ack(mw_ack), .mw_ok(mw_ok), .rqm(rqm), .dio(dio), .busy(busy),
      .mw_req(mw_req), .mw_drive(mw_drive), .mw_addr(mw_addr), .mw_fill(mw_fill),
      .st1_nw(st1_nw), .done(done)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   task automatic send(input logic [7:0] b);
      int t = 0;
      @(negedge clk);
      while (!rqm && t < 200) begin @(negedge clk); t++; end
      if (t >= 200) chk("R7 rqm timeout", 0, 1);
      host_we = 1'b1; host_data = b;
      @(negedge clk);
      host_we = 1'b0;
   endtask

   task automatic pulse_cmd();
      @(negedge clk); cmd_start = 1'b1;
      @(negedge clk); cmd_start = 1'b0;
   endtask

   task automatic serve(input int exp_addr, input logic [7:0] exp_fill, input int drv,
                        input logic ok);
      int t = 0;
      while (!mw_req && t < 50) begin @(negedge clk); t++; end
      chk("R4 write issued on head byte", int'(mw_req), 1);
      chk("R5 write address", int'(mw_addr), exp_addr);
      chk("R6 filler on request", int'(mw_fill), int'(exp_fill));
      chk("R3 drive select", int'(mw_drive), drv);
      chk("R7 rqm low while pending", int'(rqm), 0);
      host_we = 1'b1; host_data = 8'hEE;        // R7 junk byte must be dropped
      @(negedge clk);
      host_we = 1'b0;
      chk("R7 request held", int'(mw_req), 1);
      chk("R7 address held", int'(mw_addr), exp_addr);
      mw_ack = 1'b1; mw_ok = ok;
      @(negedge clk);
      mw_ack = 1'b0; mw_ok = 1'b1;
   endtask

   task automatic wait_done(input int exp_nw, input int exp_writes);
      int pulses = 0, reqs = 0;
      for (int i = 0; i < 20; i++) begin
         if (done) pulses++;
         if (mw_req) reqs++;
         @(negedge clk);
      end
      chk("R9 single done pulse", pulses, 1);
      chk("R9 dio raised", int'(dio), 1);
      chk("R9 busy cleared", int'(busy), 0);
      chk("R9 rqm cleared", int'(rqm), 0);
      chk("R8 not-writable flag", int'(st1_nw), exp_nw);
      if (exp_writes == 0) chk("R10 no write for zero count", reqs, 0);
   endtask

   task automatic run_format(input logic [7:0] spt, input logic [7:0] sides,
                             input logic [7:0] sc, input logic [7:0] fl,
                             input logic [7:0] drv, input logic [7:0] trk,
                             input logic [7:0] head, input logic [7:0] mask);
      int s;
      logic anyfail = 1'b0;
      cfg_spt = spt; cfg_sides = sides[1:0];
      pulse_cmd();
      chk("R2 busy after start", int'(busy), 1);
      chk("R2 rqm after start", int'(rqm), 1);
      chk("R2 dio low", int'(dio), 0);
      chk("R2 flag cleared", int'(st1_nw), 0);
      send(drv); send(8'h02); send(sc); send(8'h1B); send(fl);   // R3 order
      for (int k = 0; k < int'(sc); k++) begin
         s = (k == 0) ? int'(sc) : k;                            // R5 first uses SC
         send(trk);
         send(head);
         serve(s - 1 + int'(spt) * (int'(trk) * int'(sides) + int'(head)), fl,
               int'(drv[1:0]), !mask[k]);
         if (mask[k]) anyfail = 1'b1;
         if (k != int'(sc) - 1) begin
            send(8'(k + 1));
            send(8'h07);                                         // R4 size byte ignored
         end
      end
      wait_done(int'(anyfail), int'(sc));
   endtask

   // {spt, sides, sc, filler, drive, track, head, fail mask}
   localparam logic [63:0] VEC [4] = '{
      {8'd9,  8'd2, 8'd9, 8'hE5, 8'd1, 8'd3,  8'd1, 8'h00},
      {8'd18, 8'd2, 8'd3, 8'h00, 8'd2, 8'd79, 8'd0, 8'h02},
      {8'd8,  8'd1, 8'd1, 8'hF6, 8'd0, 8'd10, 8'd0, 8'h00},
      {8'd9,  8'd2, 8'd2, 8'h4E, 8'd3, 8'd0,  8'd1, 8'h01}
   };

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 rqm reset", int'(rqm), 0);
      chk("R1 dio reset", int'(dio), 0);
      chk("R1 busy reset", int'(busy), 0);
      chk("R1 req reset", int'(mw_req), 0);
      chk("R1 flag reset", int'(st1_nw), 0);
      chk("R1 done reset", int'(done), 0);
      rst_n = 1'b1;
      @(negedge clk);
      host_we = 1'b1; host_data = 8'h55;
      @(negedge clk); @(negedge clk);
      host_we = 1'b0;
      chk("R11 idle write busy", int'(busy), 0);
      chk("R11 idle write rqm", int'(rqm), 0);
      chk("R11 idle write req", int'(mw_req), 0);

      for (int v = 0; v < 4; v++)
         run_format(VEC[v][63:56], VEC[v][55:48], VEC[v][47:40], VEC[v][39:32],
                    VEC[v][31:24], VEC[v][23:16], VEC[v][15:8], VEC[v][7:0]);

      // R10 zero sector count, started right after a failing run (R8 clear)
      cfg_spt = 8'd9; cfg_sides = 2'd2;
      pulse_cmd();
      chk("R8 flag cleared by new command", int'(st1_nw), 0);
      send(8'd0); send(8'd2); send(8'd0); send(8'h1B); send(8'hAA);
      wait_done(0, 0);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule